// File: doc/BRIEF.md
# Floating-Point Status and Trap Control Register

This block keeps the status and control word of a floating-point unit. Software loads the word through a write port. Two control outputs come straight from its fields: a rounding select and a flush-to-zero enable. The datapath reports each finished operation with a completion strobe and five raw exception indications. The block then rewrites the sticky flag field and accumulates the same bits into a cause field. When a cause bit meets its matching enable bit, it raises a trap request toward the core.

Compare operations are a special case. A compare that produces an ordered result leaves the word alone. An unordered compare goes through the same update as any other operation. The arithmetic itself happens elsewhere. This block only records outcomes and decides whether to trap.

Field layout, bit 0 upward:
- Bits 1:0 are the rounding field.
- Bits 6:2 are the flags.
- Bits 11:7 are the enables.
- Bits 16:12 are the causes.
- Bit 18 is the denormal/flush bit.

Inside each five-bit field, the lowest bit is inexact, then underflow, overflow, divide-by-zero, and the highest bit is invalid.

Top module: `fpu_status_reg`

## Requirements
- R1: After reset the register reads 0, trap_req is 0 and trap_vec is 0.
- R2: A write stores wr_data masked to bits 16:0 and bit 18; bit 17 and bits 31:19 always read 0.
- R3: round_to_zero is 1 exactly when register bits 1:0 equal 2'b01; every other value means round to nearest even.
- R4: flush_en equals register bit 18.
- R5: On an updating completion, the flag field (bits 6:2) is replaced by raw_flags, with raw_flags bit 0 = inexact through bit 4 = invalid. The new value is visible on the cycle after the strobe.
- R6: When any raw flag is raised, the raised bits are ORed into the cause field (bits 16:12), and cause bits that were already set stay set.
- R7: trap_req is a one-cycle pulse, registered with the status update. It occurs when at least one raw flag is raised and the updated cause field ANDed with the enable field (bits 11:7) is non-zero. While trap_req is 1, trap_vec is 12'h120; otherwise trap_vec is 0.
- R8: An updating completion with no raw flag raised clears the flag field, leaves the cause and enable fields unchanged, and requests no trap.
- R9: A completion marked as a compare with an ordered result changes nothing in the register and requests no trap.
- R10: A compare with an unordered result follows the full update path of R5 to R7.
- R11: When a write and an updating completion fall in the same cycle, the update is applied on top of the newly written value. Its enables decide the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Value to write |
| op_done | input | 1 | Operation completion strobe |
| op_is_cmp | input | 1 | Completing operation is a compare |
| cmp_unord | input | 1 | Compare result is unordered |
| raw_flags | input | 5 | Raw exceptions: bit4 invalid, bit3 div-by-zero, bit2 overflow, bit1 underflow, bit0 inexact |
| csr_q | output | 32 | Current register value |
| round_to_zero | output | 1 | Truncating rounding selected |
| flush_en | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 12 | Trap vector code while trap_req is high |

## Verification
A software write and an operation completion can land in the same clock edge. That collision is where ordering mistakes would show up. The bench provokes it in two steps:
1. It first loads a word with no enables.
2. In a single cycle it then writes a word that sets only the inexact enable while an inexact completion arrives.

The result is judged two ways. The read-back word must hold the written enable together with the fresh flag and cause bits. A trap pulse must follow, which can only come from the enable that was just written.

// File: rtl/fpu_status_reg.sv
module fpu_status_reg #(
  parameter int          W         = 32,
  parameter int          NF        = 5,
  parameter logic [W-1:0] DEF_MASK = 32'h0005_FFFF,
  parameter logic [11:0] TRAP_CODE = 12'h120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          op_done,
  input  logic          op_is_cmp,
  input  logic          cmp_unord,
  input  logic [NF-1:0] raw_flags,
  output logic [W-1:0]  csr_q,
  output logic          round_to_zero,
  output logic          flush_en,
  output logic          trap_req,
  output logic [11:0]   trap_vec
);
  localparam int FLAG_LO  = 2;
  localparam int EN_LO    = FLAG_LO + NF;
  localparam int CAUSE_LO = EN_LO + NF;
  localparam int FTZ_BIT  = 18;
  localparam logic [1:0] RM_TRUNC = 2'b01;

  logic [W-1:0] base, nxt;
  logic         upd, trap_n;

  assign upd = op_done && (!op_is_cmp || cmp_unord);

  always_comb begin
    base   = wr_en ? (wr_data & DEF_MASK) : csr_q;
    nxt    = base;
    trap_n = 1'b0;
    if (upd) begin
      nxt[FLAG_LO +: NF] = raw_flags;
      if (|raw_flags) begin
        nxt[CAUSE_LO +: NF] = base[CAUSE_LO +: NF] | raw_flags;
        trap_n = |(nxt[CAUSE_LO +: NF] & base[EN_LO +: NF]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q    <= '0;
      trap_req <= 1'b0;
    end else begin
      csr_q    <= nxt;
      trap_req <= trap_n;
    end
  end

  assign round_to_zero = (csr_q[1:0] == RM_TRUNC);
  assign flush_en      = csr_q[FTZ_BIT];
  assign trap_vec      = trap_req ? TRAP_CODE : 12'h000;

  assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q & ~DEF_MASK) == '0);

  assert_trap_after_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(op_done));

  assert_trap_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (csr_q[CAUSE_LO +: NF] & csr_q[EN_LO +: NF]) != '0);

  assert_ordered_cmp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_done && op_is_cmp && !cmp_unord && !wr_en) |-> (csr_q == $past(csr_q)) && !trap_req);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!op_done && !wr_en)) |-> (csr_q == $past(csr_q)) && !trap_req);

  assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_done && !wr_en) |-> ((csr_q[CAUSE_LO +: NF] & $past(csr_q[CAUSE_LO +: NF])) == $past(csr_q[CAUSE_LO +: NF])));
endmodule

// File: tb/tb_fpu_status_reg.sv
module tb_fpu_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0, op_is_cmp = 1'b0, cmp_unord = 1'b0;
  logic [4:0]  raw_flags = '0;
  logic [31:0] csr_q;
  logic        round_to_zero, flush_en, trap_req;
  logic [11:0] trap_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fpu_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_done(op_done), .op_is_cmp(op_is_cmp), .cmp_unord(cmp_unord),
    .raw_flags(raw_flags), .csr_q(csr_q), .round_to_zero(round_to_zero),
    .flush_en(flush_en), .trap_req(trap_req), .trap_vec(trap_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [4:0] f, input logic cmp, input logic unord);
    @(negedge clk); op_done = 1'b1; raw_flags = f; op_is_cmp = cmp; cmp_unord = unord;
    @(negedge clk); op_done = 1'b0; raw_flags = '0; op_is_cmp = 1'b0; cmp_unord = 1'b0;
  endtask

  task automatic expect_trap(input string req, input logic exp_trap);
    check(req, {31'd0, trap_req}, {31'd0, exp_trap});
    check(req, {20'd0, trap_vec}, exp_trap ? 32'h120 : 32'h0);
  endtask

  task automatic t_reset;
    check("R1", csr_q, 32'h0);
    expect_trap("R1", 1'b0);
  endtask

  task automatic t_write_mask;
    do_write(32'hFFFF_FFFF);
    check("R2", csr_q, 32'h0005_FFFF);
    check("R3", {31'd0, round_to_zero}, 32'd0);
    check("R4", {31'd0, flush_en}, 32'd1);
    do_write(32'h0000_0001);
    check("R3", {31'd0, round_to_zero}, 32'd1);
    check("R4", {31'd0, flush_en}, 32'd0);
    do_write(32'h0000_0002);
    check("R3", {31'd0, round_to_zero}, 32'd0);
  endtask

  task automatic t_flags_cause;
    do_write(32'h0);
    do_op(5'b00001, 1'b0, 1'b0);
    check("R5", csr_q, 32'h0000_1004);
    expect_trap("R7", 1'b0);
    do_op(5'b10000, 1'b0, 1'b0);
    check("R6", csr_q, 32'h0001_1040);
    do_op(5'b00000, 1'b0, 1'b0);
    check("R8", csr_q, 32'h0001_1000);
    expect_trap("R8", 1'b0);
  endtask

  task automatic t_trap;
    do_write(32'h0000_0800);
    do_op(5'b10000, 1'b0, 1'b0);
    check("R7", csr_q, 32'h0001_0840);
    expect_trap("R7", 1'b1);
    @(negedge clk);
    expect_trap("R7", 1'b0);
    do_op(5'b00000, 1'b0, 1'b0);
    expect_trap("R8", 1'b0);
    check("R8", csr_q, 32'h0001_0800);
  endtask

  task automatic t_compare;
    do_write(32'h0000_0008);
    do_op(5'b00100, 1'b1, 1'b0);
    check("R9", csr_q, 32'h0000_0008);
    expect_trap("R9", 1'b0);
    do_write(32'h0000_0800);
    do_op(5'b10000, 1'b1, 1'b1);
    check("R10", csr_q, 32'h0001_0840);
    expect_trap("R10", 1'b1);
  endtask

  task automatic t_collision;
    do_write(32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0080;
    op_done = 1'b1; raw_flags = 5'b00001;
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0; raw_flags = '0;
    check("R11", csr_q, 32'h0000_1084);
    expect_trap("R11", 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_mask();
    t_flags_cause();
    t_trap();
    t_compare();
    t_collision();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule